// File: doc/BRIEF.md
# Bus Master Latency Watchdog

This block guards a bus master against targets that stall a transaction. A target might never signal ready, or it might keep answering with retry. While the master has a transaction open, a down-counter runs. If the counter runs out before the target moves any data, the block asks the master sequencer to end the cycle with a master abort. It also raises a sticky system-error flag.

The timeout comes from a 5-bit setting. The setting fills the upper five bits of an 8-bit counter and the lower three bits start at zero, so the timeout is the setting times eight clocks. A setting of zero turns the watchdog off.

Every cycle in which both ready strobes are low counts as a completed data phase and reloads the counter. When a transaction ends in a target retry, the counter is not reset. It keeps running through the gap and through the re-issued attempt, so a target that retries without end is aborted in the same way as a target that never answers.

The control is one state machine with five states:
- IDLE: no transaction is open. A start moves it to RUN with a reload, or to OFF if the setting is zero.
- RUN: the counter is live. In priority order:
  - a data phase with an end goes to IDLE;
  - a data phase alone reloads the counter and stays in RUN, or goes to OFF if the setting is now zero;
  - a counter value of one goes to ABORT;
  - an end by retry goes to HOLD;
  - any other end goes to IDLE.
- HOLD: the master is between retried attempts and the counter keeps running. A counter value of one goes to ABORT. A start goes back to RUN without a reload.
- OFF: the watchdog is disabled for this transaction. A start, or a data phase with a nonzero setting, reloads the counter and goes to RUN. An end goes to IDLE.
- ABORT: lasts one cycle and always returns to IDLE.

Top module: `lat_watchdog`

## Requirements
- R1: While reset is low, and in the first cycle after it, `abort_req` is 0. The same holds for `serr_flag`.
- R2: Take a nonzero setting L that is sampled with `txn_start`, and suppose no data phase follows. Then `abort_req` goes high in the cycle that follows the 8·L-th rising edge after the start edge.
- R3: A setting of 0 at the start, or at a reload, disables the watchdog. No `abort_req` follows until a later reload with a nonzero setting.
- R4: A data phase (`irdy_n`=0 and `trdy_n`=0 in the same cycle) reloads the counter to 8 times the setting at that edge. The abort then comes 8·L edges after the data edge.
- R5: A transaction that ends through `txn_end` with no retry returns the block to idle. No abort follows.
- R6: An end by retry (`txn_end`=1 with `stop_n`=0 and `trdy_n`=1) does not reset the counter. A following `txn_start` does not reset it either, so the abort comes at the time measured from the first start.
- R7: `abort_req` is a single-cycle pulse. There is exactly one pulse per expiry.
- R8: `serr_flag` becomes 1 in the same cycle as `abort_req`. It stays 1 until a cycle with `serr_clear`=1, and it is 0 after that edge. A set and a clear at the same edge leave it at 1.
- R9: A change of setting while a transaction is open has no effect until the next reload, which is a start or a data phase.
- R10: A data phase in the cycle where the counter would expire prevents the abort and reloads the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_limit | input | 5 | Timeout setting in units of 8 clocks; 0 disables |
| txn_start | input | 1 | Master begins a transaction (one cycle) |
| txn_end | input | 1 | Transaction terminates this cycle |
| irdy_n | input | 1 | Master ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| stop_n | input | 1 | Target stop request, active low |
| serr_clear | input | 1 | Clears the system-error flag |
| abort_req | output | 1 | One-cycle master-abort request |
| serr_flag | output | 1 | Sticky system-error flag, active high |

## Verification
The checker watches a set of rules on every cycle:
- the abort request is never two cycles wide;
- every abort is accompanied by the error flag;
- the flag rises only with an abort;
- the flag holds until it is cleared;
- a clear with no competing abort takes effect.

Only the bench scenarios can show the exact expiry cycle for several settings. The same applies to these behaviours:
- reload on a data phase, including in the final cycle;
- the retry gap that keeps the count running;
- the disabling effect of a zero setting;
- the deferral of a setting change until the next reload.

// File: rtl/lat_watchdog_pkg.sv
package lat_watchdog_pkg;
    typedef enum logic [2:0] {
        WD_IDLE  = 3'd0,
        WD_RUN   = 3'd1,
        WD_HOLD  = 3'd2,
        WD_OFF   = 3'd3,
        WD_ABORT = 3'd4
    } wd_state_t;
endpackage

// File: rtl/lat_watchdog_cnt.sv
module lat_watchdog_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             at_one
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign at_one = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/lat_watchdog_fsm.sv
module lat_watchdog_fsm
    import lat_watchdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic txn_start,
    input  logic txn_end,
    input  logic xfer,
    input  logic retry_term,
    input  logic cfg_zero,
    input  logic at_one,
    output logic cnt_load,
    output logic cnt_dec,
    output logic serr_set,
    output logic abort_req
);
    wd_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and counter control
    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        unique case (state_q)
            WD_IDLE: begin
                if (txn_start) begin
                    cnt_load = 1'b1;
                    state_d  = cfg_zero ? WD_OFF : WD_RUN;
                end
            end
            WD_RUN: begin
                if (xfer && txn_end) begin
                    state_d = WD_IDLE;
                end else if (xfer) begin
                    cnt_load = 1'b1;
                    state_d  = cfg_zero ? WD_OFF : WD_RUN;
                end else if (at_one) begin
                    cnt_dec = 1'b1;
                    state_d = WD_ABORT;
                end else if (txn_end) begin
                    cnt_dec = 1'b1;
                    state_d = retry_term ? WD_HOLD : WD_IDLE;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            WD_HOLD: begin
                cnt_dec = 1'b1;
                if (at_one) begin
                    state_d = WD_ABORT;
                end else if (txn_start) begin
                    state_d = WD_RUN;
                end
            end
            WD_OFF: begin
                if ((txn_start || xfer) && !cfg_zero) begin
                    cnt_load = 1'b1;
                    state_d  = WD_RUN;
                end else if (txn_end) begin
                    state_d = WD_IDLE;
                end
            end
            WD_ABORT: begin
                state_d = WD_IDLE;
            end
            default: begin
                state_d = WD_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        abort_req = (state_q == WD_ABORT);
        serr_set  = (state_d == WD_ABORT) && (state_q != WD_ABORT);
    end
endmodule

// File: rtl/lat_watchdog_flag.sv
module lat_watchdog_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clear,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clear) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/lat_watchdog.sv
module lat_watchdog #(
    parameter int SET_W  = 5,
    parameter int FRAC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] cfg_limit,
    input  logic             txn_start,
    input  logic             txn_end,
    input  logic             irdy_n,
    input  logic             trdy_n,
    input  logic             stop_n,
    input  logic             serr_clear,
    output logic             abort_req,
    output logic             serr_flag
);
    localparam int CNT_W = SET_W + FRAC_W;

    logic             xfer;
    logic             retry_term;
    logic             cfg_zero;
    logic             at_one;
    logic             cnt_load;
    logic             cnt_dec;
    logic             serr_set;
    logic [CNT_W-1:0] load_val;

    assign xfer       = !irdy_n && !trdy_n;
    assign retry_term = !stop_n && trdy_n;
    assign cfg_zero   = (cfg_limit == '0);
    assign load_val   = {cfg_limit, {FRAC_W{1'b0}}};

    lat_watchdog_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (load_val),
        .dec      (cnt_dec),
        .at_one   (at_one)
    );

    lat_watchdog_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .txn_start  (txn_start),
        .txn_end    (txn_end),
        .xfer       (xfer),
        .retry_term (retry_term),
        .cfg_zero   (cfg_zero),
        .at_one     (at_one),
        .cnt_load   (cnt_load),
        .cnt_dec    (cnt_dec),
        .serr_set   (serr_set),
        .abort_req  (abort_req)
    );

    lat_watchdog_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (serr_set),
        .clear (serr_clear),
        .flag  (serr_flag)
    );
endmodule

// File: rtl/lat_watchdog_chk.sv
module lat_watchdog_chk (
    input logic clk,
    input logic rst_n,
    input logic serr_clear,
    input logic abort_req,
    input logic serr_flag
);
    // R7
    abort_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |=> !abort_req);

    // R8
    abort_serr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |-> serr_flag);

    // R8
    serr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(serr_flag) |-> abort_req);

    // R8
    serr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (serr_flag && !serr_clear) |=> serr_flag);

    // R8
    serr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        serr_clear |=> (!serr_flag || abort_req));
endmodule

bind lat_watchdog lat_watchdog_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .serr_clear (serr_clear),
    .abort_req  (abort_req),
    .serr_flag  (serr_flag)
);

// File: tb/lat_watchdog_tb_top.sv
module lat_watchdog_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [4:0] cfg_limit;
    logic       txn_start, txn_end, irdy_n, trdy_n, stop_n, serr_clear;
    logic       abort_req, serr_flag;

    always #5 clk = ~clk;

    lat_watchdog dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_limit(cfg_limit),
        .txn_start(txn_start), .txn_end(txn_end), .irdy_n(irdy_n),
        .trdy_n(trdy_n), .stop_n(stop_n), .serr_clear(serr_clear),
        .abort_req(abort_req), .serr_flag(serr_flag)
    );

    typedef struct packed {
        logic [4:0] s1;
        logic [4:0] s2;
        logic [9:0] xfer_c;
        logic [9:0] retry_c;
        logic [9:0] end_c;
        logic [9:0] exp_c;
    } vec_t;

    localparam int NV = 12;
    localparam int W  = 300;
    localparam vec_t VECS [NV] = '{
        '{5'd1,  5'd1,  10'd0,  10'd0, 10'd0,  10'd8},
        '{5'd4,  5'd4,  10'd0,  10'd0, 10'd0,  10'd32},
        '{5'd31, 5'd31, 10'd0,  10'd0, 10'd0,  10'd248},
        '{5'd0,  5'd0,  10'd0,  10'd0, 10'd0,  10'd0},
        '{5'd2,  5'd2,  10'd10, 10'd0, 10'd0,  10'd26},
        '{5'd2,  5'd2,  10'd16, 10'd0, 10'd0,  10'd32},
        '{5'd3,  5'd3,  10'd0,  10'd0, 10'd10, 10'd0},
        '{5'd2,  5'd2,  10'd0,  10'd5, 10'd0,  10'd16},
        '{5'd2,  5'd5,  10'd0,  10'd0, 10'd0,  10'd16},
        '{5'd2,  5'd5,  10'd6,  10'd0, 10'd0,  10'd46},
        '{5'd1,  5'd0,  10'd4,  10'd0, 10'd0,  10'd0},
        '{5'd0,  5'd3,  10'd0,  10'd0, 10'd0,  10'd0}
    };

    function automatic string vtag(int i);
        case (i)
            0, 1, 2: return "R2";
            3, 10:   return "R3";
            4:       return "R4";
            5:       return "R10";
            6:       return "R5";
            7:       return "R6";
            default: return "R9";
        endcase
    endfunction

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    task automatic idle_inputs();
        txn_start = 1'b0; txn_end = 1'b0; irdy_n = 1'b1;
        trdy_n = 1'b1; stop_n = 1'b1; serr_clear = 1'b0;
    endtask

    task automatic clear_flag();
        serr_clear = 1'b1;
        @(posedge clk); @(negedge clk);
        serr_clear = 1'b0;
        check("R8 clear", int'(serr_flag), 0);
    endtask

    task automatic run_vec(int idx);
        vec_t v;
        int   first;
        int   pulses;
        v = VECS[idx];
        first = 0;
        pulses = 0;
        for (int k = 0; k <= W; k++) begin
            txn_start = (k == 0) || (v.retry_c != 0 && k == int'(v.retry_c) + 2);
            cfg_limit = (k == 0) ? v.s1 : v.s2;
            trdy_n    = !(v.xfer_c != 0 && k == int'(v.xfer_c));
            txn_end   = (v.retry_c != 0 && k == int'(v.retry_c)) ||
                        (v.end_c != 0 && k == int'(v.end_c));
            stop_n    = !(v.retry_c != 0 && k == int'(v.retry_c));
            irdy_n    = 1'b0;
            @(posedge clk); @(negedge clk);
            if (abort_req) begin
                pulses++;
                if (first == 0) first = k;
            end
        end
        idle_inputs();
        check(vtag(idx), first, int'(v.exp_c));
        check("R7 pulse count", pulses, (v.exp_c != 0) ? 1 : 0);
        check("R8 flag", int'(serr_flag), (v.exp_c != 0) ? 1 : 0);
        clear_flag();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        idle_inputs();
        cfg_limit = 5'd0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 during reset
        check("R1 abort", int'(abort_req), 0);
        check("R1 serr", int'(serr_flag), 0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R1 abort after", int'(abort_req), 0);
        check("R1 serr after", int'(serr_flag), 0);

        for (int i = 0; i < NV; i++) begin
            run_vec(i);
        end

        // R8 set wins over clear at the expiry edge
        for (int k = 0; k <= 12; k++) begin
            txn_start  = (k == 0);
            cfg_limit  = 5'd1;
            irdy_n     = 1'b0;
            serr_clear = (k == 8);
            @(posedge clk); @(negedge clk);
            if (k == 8) begin
                check("R8 abort at 8", int'(abort_req), 1);
                check("R8 set wins", int'(serr_flag), 1);
            end
        end
        idle_inputs();
        check("R8 sticky", int'(serr_flag), 1);
        clear_flag();

        // R1 reset clears a set flag
        for (int k = 0; k <= 9; k++) begin
            txn_start = (k == 0);
            irdy_n    = 1'b0;
            @(posedge clk); @(negedge clk);
        end
        idle_inputs();
        check("R8 set before reset", int'(serr_flag), 1);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1 reset clears flag", int'(serr_flag), 0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);

        finish_run();
    end
endmodule